// File: doc/BRIEF.md
# Coincidence Event Acceptance Sequencer

The block watches four detector timing pulses and collects them into one event. The first pulse on any line opens a capture window. The window stays open for a programmable number of clocks. At the end of the window, the block has recorded which lines fired and whether the event began with a stop pulse and no start pulse. Lines A and B are the start lines; C and D are the stop lines.

These two pieces of information form an index into a writable single-bit acceptance table. The table decides whether the event is kept. A separate control can veto every event that began with a stop pulse. For a kept event, the block drives an external time-to-digital converter through a request/ready handshake, one channel after another, in a fixed order. It then presents one record on a valid/ready output.

In rates-only mode, a kept event only advances an event counter. No conversion is requested and no record is produced.

Top module: `coinc_accept_seq`

## Requirements
- R1: After reset, every acceptance table entry rejects, no conversion is requested, no record is valid, and the event counter reads zero.
- R2: Pulse lines map to hit bits as A=bit0, B=bit1, C=bit2, D=bit3. The hit pattern is the OR of the pulses seen in the opening clock and in the following `win_len_i` clocks. A `win_len_i` of zero acts as one.
- R3: The stop-first flag is set when the opening clock has C or D high while A and B are both low. Otherwise the flag is clear.
- R4: The table index is {hits[3:0], stop-first flag}, which places the flag at bit 0. An entry value of 1 accepts the event and 0 rejects it. The table is written through `tbl_we_i`/`tbl_addr_i`/`tbl_data_i`.
- R5: When the stop-first flag is set and `sf_ok_i` is low, the event is rejected whatever the table holds.
- R6: Conversions follow a fixed channel-code order: 0 (A−C time of flight), then 1 (B−D time of flight), then 2 (A−B position), then 3 (C−D position). Each request is held with a stable code until `conv_rdy_i` is high. Only then is the next code requested.
- R7: A record carries the hit pattern, the stop-first flag, and four results. The result for channel code k sits in `ev_tdc_o[k*TDC_W +: TDC_W]`. While `ev_ready_i` is low, `ev_valid_o` and all record fields hold stable.
- R8: In rates-only mode, an accepted event requests no conversion and produces no record.
- R9: The event counter increases by exactly one for each accepted event, in either mode. Rejected events leave it unchanged.
- R10: Pulses that arrive after the window has closed are ignored until the block returns to idle. This covers the decision clock, the conversions and the output stage. Such pulses neither alter the record nor start a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 4 | Timing pulses A (bit0) to D (bit3) |
| win_len_i | input | WIN_W | Window length in clocks after the opening clock |
| sf_ok_i | input | 1 | Allows stop-first events to reach the table |
| rates_only_i | input | 1 | Count only; no conversions or records |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 5 | Table write index |
| tbl_data_i | input | 1 | Table write value (1 = accept) |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | 2 | Requested channel code |
| conv_rdy_i | input | 1 | Conversion result ready |
| conv_data_i | input | TDC_W | Conversion result |
| ev_valid_o | output | 1 | Record valid |
| ev_ready_i | input | 1 | Record accepted by sink |
| ev_hits_o | output | 4 | Record hit pattern |
| ev_sf_o | output | 1 | Record stop-first flag |
| ev_tdc_o | output | 4*TDC_W | Record results, channel code 0 in the low bits |
| evt_count_o | output | CNT_W | Accepted event counter |

## Verification
The bench sweeps every non-empty hit pattern. Each pattern is sent both as a single simultaneous burst and as a stop-then-start arrival. It runs against two complementary table contents, once with the stop-first veto on and once with it off. A design that built the index in the wrong order, or computed the flag from the whole window instead of the opening clock, would keep or drop the wrong events.

A pulse is placed on the last clock of the window and another on the first clock after it. A third pulse arrives in the middle of the conversions. An off-by-one window or a sequencer that still listens would change the hit pattern or start a phantom event.

The record is held under backpressure to show that a stalled output is not lost or altered. The converter model logs the channel codes it sees, so a sequencer that skips channels, reorders them, or moves on before ready is exposed. Rates-only events check that the counter moves while the converter stays silent.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;
    localparam int HIT_W  = 4;
    localparam int IDX_W  = HIT_W + 1;
    localparam int TBL_N  = 1 << IDX_W;

    localparam logic [HIT_W-1:0] START_MASK = 4'b0011;
    localparam logic [HIT_W-1:0] STOP_MASK  = 4'b1100;
    localparam logic [CH_W-1:0]  LAST_CH    = CH_W'(NUM_CH - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN,
        ST_DECIDE,
        ST_CONV,
        ST_OUT
    } seq_state_e;

    typedef struct packed {
        logic [HIT_W-1:0] hits;
        logic             sf;
    } ev_tag_t;

    function automatic logic stop_first(input logic [HIT_W-1:0] p);
        return ((p & STOP_MASK) != '0) && ((p & START_MASK) == '0);
    endfunction

    function automatic logic [IDX_W-1:0] tbl_index(input ev_tag_t t);
        return {t.hits, t.sf};
    endfunction

endpackage

// File: rtl/coinc_lut.sv
module coinc_lut
    import coinc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic             wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic             rdata_o
);

    logic [TBL_N-1:0] entry_q;

    generate
        for (genvar i = 0; i < TBL_N; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)
                    entry_q[i] <= 1'b0;
                else if (we_i && waddr_i == IDX_W'(i))
                    entry_q[i] <= wdata_i;
            end
        end
    endgenerate

    assign rdata_o = entry_q[raddr_i];

endmodule

// File: rtl/coinc_capture.sv
module coinc_capture
    import coinc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             grow_i,
    input  logic [HIT_W-1:0] pulse_i,
    output ev_tag_t          tag_o
);

    ev_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (open_i) begin
            tag_q.hits <= pulse_i;
            tag_q.sf   <= stop_first(pulse_i);
        end else if (grow_i) begin
            tag_q.hits <= tag_q.hits | pulse_i;
        end
    end

    assign tag_o = tag_q;

    AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (grow_i && !open_i) |=> $stable(tag_q.sf)) else $error("flag moved in window"); // R3

endmodule

// File: rtl/coinc_readout.sv
module coinc_readout
    import coinc_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 rdy_i,
    input  logic [DW-1:0]        data_i,
    output logic                 req_o,
    output logic [CH_W-1:0]      ch_o,
    output logic                 done_o,
    output logic [NUM_CH*DW-1:0] res_o
);

    logic            active_q;
    logic [CH_W-1:0] ch_q;
    logic            take;

    assign take = active_q && rdy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            ch_q     <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            ch_q     <= '0;
        end else if (take) begin
            if (ch_q == LAST_CH)
                active_q <= 1'b0;
            else
                ch_q <= ch_q + 1'b1;
        end
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_res
            always_ff @(posedge clk) begin
                if (rst)
                    res_o[k*DW +: DW] <= '0;
                else if (take && ch_q == CH_W'(k))
                    res_o[k*DW +: DW] <= data_i;
            end
        end
    endgenerate

    assign req_o  = active_q;
    assign ch_o   = ch_q;
    assign done_o = take && (ch_q == LAST_CH);

    AST_CONV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_o && !rdy_i) |=> (req_o && $stable(ch_o))) else $error("request dropped"); // R6
    AST_CONV_ORDER: assert property (@(posedge clk) disable iff (rst)
        (req_o && rdy_i && ch_o != LAST_CH) |=> (req_o && ch_o == $past(ch_o) + 1'b1)) else $error("order"); // R6
    AST_CONV_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> (ch_o == '0)) else $error("first channel"); // R6

endmodule

// File: rtl/coinc_accept_seq.sv
module coinc_accept_seq
    import coinc_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int TDC_W = 12,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              pulse_i,
    input  logic [WIN_W-1:0]        win_len_i,
    input  logic                    sf_ok_i,
    input  logic                    rates_only_i,
    input  logic                    tbl_we_i,
    input  logic [4:0]              tbl_addr_i,
    input  logic                    tbl_data_i,
    output logic                    conv_req_o,
    output logic [1:0]              conv_ch_o,
    input  logic                    conv_rdy_i,
    input  logic [TDC_W-1:0]        conv_data_i,
    output logic                    ev_valid_o,
    input  logic                    ev_ready_i,
    output logic [3:0]              ev_hits_o,
    output logic                    ev_sf_o,
    output logic [4*TDC_W-1:0]      ev_tdc_o,
    output logic [CNT_W-1:0]        evt_count_o
);

    localparam int WC_W = WIN_W + 1;

    seq_state_e       state_q;
    logic [WIN_W-1:0] win_cnt_q;
    logic [CNT_W-1:0] cnt_q;
    ev_tag_t          tag;
    logic             open_ev, grow, win_last, tbl_bit, accept, deciding;
    logic             ro_start, ro_done;

    assign open_ev  = (state_q == ST_IDLE) && (pulse_i != '0);
    assign grow     = (state_q == ST_WIN);
    assign deciding = (state_q == ST_DECIDE);
    assign win_last = (WC_W'(win_cnt_q) + WC_W'(1)) >= WC_W'(win_len_i);
    assign accept   = tbl_bit && (!tag.sf || sf_ok_i);
    assign ro_start = deciding && accept && !rates_only_i;

    coinc_lut u_lut (
        .clk     (clk),
        .rst     (rst),
        .we_i    (tbl_we_i),
        .waddr_i (tbl_addr_i),
        .wdata_i (tbl_data_i),
        .raddr_i (tbl_index(tag)),
        .rdata_o (tbl_bit)
    );

    coinc_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .open_i  (open_ev),
        .grow_i  (grow),
        .pulse_i (pulse_i),
        .tag_o   (tag)
    );

    coinc_readout #(.DW(TDC_W)) u_ro (
        .clk     (clk),
        .rst     (rst),
        .start_i (ro_start),
        .rdy_i   (conv_rdy_i),
        .data_i  (conv_data_i),
        .req_o   (conv_req_o),
        .ch_o    (conv_ch_o),
        .done_o  (ro_done),
        .res_o   (ev_tdc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            win_cnt_q <= '0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (open_ev) begin
                    state_q   <= ST_WIN;
                    win_cnt_q <= '0;
                end
                ST_WIN: begin
                    if (win_last) state_q <= ST_DECIDE;
                    else          win_cnt_q <= win_cnt_q + 1'b1;
                end
                ST_DECIDE: begin
                    if (accept) cnt_q <= cnt_q + 1'b1;
                    state_q <= ro_start ? ST_CONV : ST_IDLE;
                end
                ST_CONV: if (ro_done) state_q <= ST_OUT;
                ST_OUT:  if (ev_ready_i) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ev_valid_o  = (state_q == ST_OUT);
    assign ev_hits_o   = tag.hits;
    assign ev_sf_o     = tag.sf;
    assign evt_count_o = cnt_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev_valid_o && !ev_ready_i) |=> (ev_valid_o && $stable(ev_hits_o) && $stable(ev_sf_o)
                                         && $stable(ev_tdc_o))) else $error("record lost"); // R7
    AST_RATES_NOREQ: assert property (@(posedge clk) disable iff (rst)
        (deciding && rates_only_i) |=> (!conv_req_o && !ev_valid_o)) else $error("rates conv"); // R8
    AST_SF_VETO: assert property (@(posedge clk) disable iff (rst)
        (deciding && tag.sf && !sf_ok_i) |=> (state_q == ST_IDLE && $stable(evt_count_o))) else $error("veto"); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(evt_count_o) |-> (evt_count_o == $past(evt_count_o) + 1'b1)) else $error("count step"); // R9
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(conv_req_o && ev_valid_o)) else $error("overlap"); // R10

endmodule

// File: tb/coinc_accept_seq_tb_top.sv
module coinc_accept_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TDC_W      = 12;
    localparam int WIN_LEN    = 3;
    localparam int CONV_LAT   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        pulse = '0;
    logic [7:0]        win_len = 8'(WIN_LEN);
    logic              sf_ok = 1'b0;
    logic              rates_only = 1'b0;
    logic              tbl_we = 1'b0;
    logic [4:0]        tbl_addr = '0;
    logic              tbl_data = 1'b0;
    logic              conv_req;
    logic [1:0]        conv_ch;
    logic              conv_rdy = 1'b0;
    logic [TDC_W-1:0]  conv_data = '0;
    logic              ev_valid;
    logic              ev_ready = 1'b1;
    logic [3:0]        ev_hits;
    logic              ev_sf;
    logic [4*TDC_W-1:0] ev_tdc;
    logic [15:0]       evt_count;

    int checks = 0;
    int errors = 0;
    int cur_id = 0;
    int nseen  = 0;
    int wait_cnt = 0;
    int seen_ch [8];
    bit tbl_model [32];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coinc_accept_seq dut_i (
        .clk(clk), .rst(rst), .pulse_i(pulse), .win_len_i(win_len),
        .sf_ok_i(sf_ok), .rates_only_i(rates_only),
        .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
        .conv_req_o(conv_req), .conv_ch_o(conv_ch), .conv_rdy_i(conv_rdy),
        .conv_data_i(conv_data), .ev_valid_o(ev_valid), .ev_ready_i(ev_ready),
        .ev_hits_o(ev_hits), .ev_sf_o(ev_sf), .ev_tdc_o(ev_tdc),
        .evt_count_o(evt_count)
    );

    // converter model: answers each request after CONV_LAT idle clocks
    initial begin
        forever begin
            @(negedge clk);
            conv_rdy = 1'b0;
            if (conv_req) begin
                if (wait_cnt == CONV_LAT) begin
                    conv_rdy  = 1'b1;
                    conv_data = TDC_W'((int'(conv_ch) + 1) * 256 + (cur_id & 255));
                    if (nseen < 8) seen_ch[nseen] = int'(conv_ch);
                    nseen++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_tbl(input int idx, input bit v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 5'(idx); tbl_data = v;
        @(negedge clk);
        tbl_we = 1'b0;
        tbl_model[idx] = v;
    endtask

    // first pattern in the opening clock, extra pattern at clock offset gap
    task automatic send(input logic [3:0] first, input logic [3:0] extra, input int gap);
        for (int c = 0; c <= gap; c++) begin
            @(negedge clk);
            pulse = (c == 0) ? (gap == 0 ? (first | extra) : first) : ((c == gap) ? extra : 4'b0);
        end
        @(negedge clk);
        pulse = '0;
    endtask

    task automatic run_event(input logic [3:0] first, input logic [3:0] extra, input int gap,
                             input logic [3:0] exp_hits, input bit exp_sf, input string req);
        bit exp_acc;
        bit got;
        int base;
        cur_id++;
        nseen = 0;
        base = int'(evt_count);
        exp_acc = tbl_model[{exp_hits, exp_sf}] && (!exp_sf || sf_ok);
        send(first, extra, gap);
        got = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (ev_valid) got = 1'b1;
        end
        if (exp_acc && !rates_only) begin
            chk(got, req, "record valid", int'(got), 1);
            if (got) begin
                chk(ev_hits == exp_hits, "R2", "hits", int'(ev_hits), int'(exp_hits));
                chk(ev_sf == exp_sf, "R3", "stop-first", int'(ev_sf), int'(exp_sf));
                for (int k = 0; k < 4; k++)
                    chk(int'(ev_tdc[k*TDC_W +: TDC_W]) == (k + 1) * 256 + (cur_id & 255), "R7",
                        "result", int'(ev_tdc[k*TDC_W +: TDC_W]), (k + 1) * 256 + (cur_id & 255));
                chk(nseen == 4, "R6", "requests", nseen, 4);
                for (int k = 0; k < 4 && k < nseen; k++)
                    chk(seen_ch[k] == k, "R6", "channel order", seen_ch[k], k);
                @(negedge clk);
            end
        end else begin
            chk(!got, rates_only ? "R8" : "R4", "no record", int'(got), 0);
            chk(nseen == 0, rates_only ? "R8" : "R5", "no conversion", nseen, 0);
        end
        repeat (2) @(negedge clk);
        chk(!ev_valid, "R10", "no phantom event", int'(ev_valid), 0);
        chk(int'(evt_count) == base + int'(exp_acc), "R9", "event count",
            int'(evt_count), base + int'(exp_acc));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!conv_req, "R1", "conv_req", int'(conv_req), 0);
        chk(!ev_valid, "R1", "ev_valid", int'(ev_valid), 0);
        chk(evt_count == 0, "R1", "count", int'(evt_count), 0);
        for (int i = 0; i < 32; i++) tbl_model[i] = 1'b0;
        run_event(4'b1111, 4'b0, 0, 4'b1111, 1'b0, "R1");
        run_event(4'b0101, 4'b0, 0, 4'b0101, 1'b0, "R1");

        // near-exhaustive sweep: two table contents, veto on and off
        for (int pass = 0; pass < 2; pass++) begin
            sf_ok = (pass == 1);
            for (int i = 0; i < 32; i++)
                wr_tbl(i, (((i * 5 + 1) % 3) != 0) ^ (pass == 1));
            for (int h = 1; h < 16; h++) begin
                for (int style = 0; style < 2; style++) begin
                    logic [3:0] hv, fst, ext;
                    bit sfx;
                    hv  = 4'(h);
                    fst = (style == 1 && (hv & 4'b1100) != 0) ? (hv & 4'b1100) : hv;
                    ext = hv & ~fst;
                    sfx = ((fst & 4'b1100) != 0) && ((fst & 4'b0011) == 0);
                    run_event(fst, ext, (ext != 0) ? 1 : 0, hv, sfx, "R4");
                end
            end
        end

        // window edge: last captured clock and first ignored clock (R2, R10)
        sf_ok = 1'b0;
        wr_tbl(2, 1'b1);   // {0001,0}
        wr_tbl(6, 1'b1);   // {0011,0}
        wr_tbl(22, 1'b1);  // {1011,0}
        run_event(4'b0001, 4'b0010, WIN_LEN, 4'b0011, 1'b0, "R2");
        run_event(4'b0001, 4'b0010, WIN_LEN + 1, 4'b0001, 1'b0, "R10");
        // pulse in the middle of conversions is ignored
        run_event(4'b0001, 4'b1000, WIN_LEN + 5, 4'b0001, 1'b0, "R10");

        // stop-first veto with table accepting: {0100,1}
        wr_tbl(9, 1'b1);
        run_event(4'b0100, 4'b0, 0, 4'b0100, 1'b1, "R5");
        sf_ok = 1'b1;
        run_event(4'b0100, 4'b0, 0, 4'b0100, 1'b1, "R5");

        // backpressure holds the record (R7)
        begin
            logic [4*TDC_W-1:0] snap;
            bit got;
            int base;
            cur_id++; nseen = 0; base = int'(evt_count);
            ev_ready = 1'b0;
            send(4'b0011, 4'b0, 0);
            got = 1'b0;
            for (int i = 0; i < 40 && !got; i++) begin
                @(negedge clk);
                if (ev_valid) got = 1'b1;
            end
            chk(got, "R7", "stalled record valid", int'(got), 1);
            snap = ev_tdc;
            repeat (6) @(negedge clk);
            chk(ev_valid, "R7", "valid held", int'(ev_valid), 1);
            chk(ev_tdc == snap && ev_hits == 4'b0011, "R7", "record stable", int'(ev_hits), 3);
            chk(int'(ev_tdc[TDC_W-1:0]) == 256 + (cur_id & 255), "R7", "ch0 result",
                int'(ev_tdc[TDC_W-1:0]), 256 + (cur_id & 255));
            ev_ready = 1'b1;
            @(negedge clk);
            chk(!ev_valid, "R7", "released", int'(ev_valid), 0);
            chk(int'(evt_count) == base + 1, "R9", "count", int'(evt_count), base + 1);
        end

        // rates-only mode (R8)
        rates_only = 1'b1;
        run_event(4'b0011, 4'b0, 0, 4'b0011, 1'b0, "R8");
        run_event(4'b0001, 4'b0, 0, 4'b0001, 1'b0, "R8");
        run_event(4'b1111, 4'b0, 0, 4'b1111, 1'b0, "R8");
        rates_only = 1'b0;

        // zero window length behaves as one (R2)
        win_len = 8'd0;
        run_event(4'b0001, 4'b0010, 1, 4'b0011, 1'b0, "R2");
        run_event(4'b0001, 4'b0010, 2, 4'b0001, 1'b0, "R2");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule